// File: doc/BRIEF.md
# Eight-bit bidirectional shift register with shared parallel port

This block is an eight-bit register that, on every rising clock edge, either keeps its contents, moves them one place toward the high end, moves them one place toward the low end, or takes a new word from a parallel port. Two mode-select inputs pick the operation. An active-low reset clears the register at once, without waiting for a clock edge.

The parallel port is shared between reading and writing. On the chip boundary it would be a set of bidirectional pins. Here it is modelled as three signals: a data input bus, a data output bus and a single output-enable flag. The output driver is switched off by either of two active-high disable inputs. It is also switched off automatically whenever the load mode is selected, so that outside logic can drive the port. Switching the driver off does not stop the register: it keeps shifting, loading and resetting.

The lowest and highest bits are always present on two dedicated serial outputs. Several of these blocks can therefore be chained into longer words.

Top module: `univ_shift_reg`

## Requirements
- R1: A low level on `rst_ni` clears all eight register bits immediately, without waiting for a clock edge; `pbus_o`, `tap_first_o` and `tap_last_o` read 0.
- R2: With {`mode_sel1_i`,`mode_sel0_i`} = 2'b00 (hold), a rising edge leaves the register unchanged, whatever the serial and parallel inputs are.
- R3: With {`mode_sel1_i`,`mode_sel0_i`} = 2'b01 (shift toward the high end), a rising edge moves bit n into bit n+1 and loads bit 0 from `ser_right_i`.
- R4: With {`mode_sel1_i`,`mode_sel0_i`} = 2'b10 (shift toward the low end), a rising edge moves bit n+1 into bit n and loads bit 7 from `ser_left_i`.
- R5: With {`mode_sel1_i`,`mode_sel0_i`} = 2'b11 (parallel load), a rising edge copies `pbus_i` into the register.
- R6: `pbus_oe_o` is combinational. It is 1 only when `out_dis0_i` and `out_dis1_i` are both 0 and the mode is not 2'b11.
- R7: While `pbus_oe_o` is 0, shifting, loading and reset still update the register, and `pbus_o` always shows the register contents.
- R8: `tap_first_o` always equals register bit 0 and `tap_last_o` always equals bit 7, regardless of the output-enable state.
- R9: While `rst_ni` is low, clock edges change nothing, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel0_i | input | 1 | Mode select, low bit |
| mode_sel1_i | input | 1 | Mode select, high bit |
| out_dis0_i | input | 1 | Parallel output disable, active high |
| out_dis1_i | input | 1 | Parallel output disable, active high |
| ser_right_i | input | 1 | Serial input to bit 0 in the 2'b01 shift |
| ser_left_i | input | 1 | Serial input to bit 7 in the 2'b10 shift |
| pbus_i | input | 8 | Value driven onto the shared port from outside |
| pbus_o | output | 8 | Register contents offered to the shared port |
| pbus_oe_o | output | 1 | Driver enable for the shared port |
| tap_first_o | output | 1 | Register bit 0, always driven |
| tap_last_o | output | 1 | Register bit 7, always driven |

## Verification
The bench runs a chain of loads and of shifts in both directions, feeding in both serial values. A design that reverses the direction, or takes the serial bit from the wrong input, fails on the first shift.

All sixteen combinations of the two disables and the mode are checked against the output enable. This catches an enable that ignores one disable input, or one that stays on during a load and would fight the outside driver.

Reset is asserted while the clock is high, in the middle of a cycle. The register must clear before the next edge and stay clear across edges in load mode. A reset that waits for a clock edge, or that loses to the mode selects, shows up here.

The bench also loads and shifts with the driver switched off, then switches it back on. A design that freezes the register while the port is disabled returns stale data.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_SHR  = 2'b01,
    OP_SHL  = 2'b10,
    OP_LOAD = 2'b11
  } shift_op_e;
endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
(
  input  logic      sel0_i,
  input  logic      sel1_i,
  input  logic      dis0_i,
  input  logic      dis1_i,
  output shift_op_e op_o,
  output logic      clk_en_o,
  output logic      oe_o
);
  always_comb begin
    op_o     = shift_op_e'({sel1_i, sel0_i});
    // Hold needs no edge: gate the register instead of recirculating.
    clk_en_o = (op_o != OP_HOLD);
    // The load mode releases the port so that outside logic can drive it.
    oe_o     = !dis0_i && !dis1_i && (op_o != OP_LOAD);
  end
endmodule

// File: rtl/ushift_nextstate.sv
module ushift_nextstate
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_op_e        op_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             ser_right_i,
  input  logic             ser_left_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] d_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_lo;
    logic from_hi;

    if (i == 0) begin : g_lo_edge
      assign from_lo = ser_right_i;
    end else begin : g_lo_mid
      assign from_lo = q_i[i-1];
    end

    if (i == WIDTH - 1) begin : g_hi_edge
      assign from_hi = ser_left_i;
    end else begin : g_hi_mid
      assign from_hi = q_i[i+1];
    end

    always_comb begin
      unique case (op_i)
        OP_SHR:  d_o[i] = from_lo;
        OP_SHL:  d_o[i] = from_hi;
        OP_LOAD: d_o[i] = par_i[i];
        default: d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/ushift_regs.sv
module ushift_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_sel0_i,
  input  logic             mode_sel1_i,
  input  logic             out_dis0_i,
  input  logic             out_dis1_i,
  input  logic             ser_right_i,
  input  logic             ser_left_i,
  input  logic [WIDTH-1:0] pbus_i,
  output logic [WIDTH-1:0] pbus_o,
  output logic             pbus_oe_o,
  output logic             tap_first_o,
  output logic             tap_last_o
);
  localparam int MSB = WIDTH - 1;

  shift_op_e        op;
  logic             clk_en;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  ushift_ctrl u_ctrl (
    .sel0_i   (mode_sel0_i),
    .sel1_i   (mode_sel1_i),
    .dis0_i   (out_dis0_i),
    .dis1_i   (out_dis1_i),
    .op_o     (op),
    .clk_en_o (clk_en),
    .oe_o     (pbus_oe_o)
  );

  ushift_nextstate #(.WIDTH(WIDTH)) u_next (
    .op_i        (op),
    .q_i         (state_q),
    .ser_right_i (ser_right_i),
    .ser_left_i  (ser_left_i),
    .par_i       (pbus_i),
    .d_o         (state_d)
  );

  ushift_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  // The register is offered on the port at all times; the enable flag
  // says whether the driver is active.
  assign pbus_o      = state_q;
  assign tap_first_o = state_q[0];
  assign tap_last_o  = state_q[MSB];
endmodule

// File: rtl/ushift_checker.sv
module ushift_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_sel0_i,
  input logic             mode_sel1_i,
  input logic             out_dis0_i,
  input logic             out_dis1_i,
  input logic             ser_right_i,
  input logic             ser_left_i,
  input logic [WIDTH-1:0] pbus_i,
  input logic [WIDTH-1:0] pbus_o,
  input logic             pbus_oe_o,
  input logic             tap_first_o,
  input logic             tap_last_o
);
  logic [1:0] mode;
  assign mode = {mode_sel1_i, mode_sel0_i};

  // R1, R9: cleared whenever reset is held at an edge
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (pbus_o == '0);
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b00) |=> (pbus_o == $past(pbus_o)));

  assert_shift_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b01) |=> (pbus_o == {$past(pbus_o[WIDTH-2:0]), $past(ser_right_i)}));

  assert_shift_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b10) |=> (pbus_o == {$past(ser_left_i), $past(pbus_o[WIDTH-1:1])}));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b11) |=> (pbus_o == $past(pbus_i)));

  assert_dis_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_dis0_i || out_dis1_i) |-> !pbus_oe_o);

  assert_load_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b11) |-> !pbus_oe_o);

  assert_taps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_first_o == pbus_o[0]) && (tap_last_o == pbus_o[WIDTH-1]));
endmodule

bind univ_shift_reg ushift_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_sel0_i (mode_sel0_i),
  .mode_sel1_i (mode_sel1_i),
  .out_dis0_i  (out_dis0_i),
  .out_dis1_i  (out_dis1_i),
  .ser_right_i (ser_right_i),
  .ser_left_i  (ser_left_i),
  .pbus_i      (pbus_i),
  .pbus_o      (pbus_o),
  .pbus_oe_o   (pbus_oe_o),
  .tap_first_o (tap_first_o),
  .tap_last_o  (tap_last_o)
);

// File: tb/univ_shift_reg_test.sv
module univ_shift_reg_test;
  logic       clk;
  logic       rst_n;
  logic       s0, s1, d0, d1, sr, sl;
  logic [7:0] pin;
  logic [7:0] pout;
  logic       oe, tfirst, tlast;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  univ_shift_reg #(.WIDTH(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_sel0_i(s0), .mode_sel1_i(s1),
    .out_dis0_i(d0), .out_dis1_i(d1), .ser_right_i(sr), .ser_left_i(sl),
    .pbus_i(pin), .pbus_o(pout), .pbus_oe_o(oe),
    .tap_first_o(tfirst), .tap_last_o(tlast)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // Each row: {mode[1:0], ser_right, ser_left, pbus_i[7:0], expected[7:0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R5 load
    {2'b00, 1'b1, 1'b1, 8'hFF, 8'hA5},  // R2 hold
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},  // R3 shift up, 1 in
    {2'b01, 1'b0, 1'b1, 8'h00, 8'h96},  // R3 shift up, 0 in
    {2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},  // R4 shift down, 1 in
    {2'b10, 1'b1, 1'b0, 8'h00, 8'h65},  // R4 shift down, 0 in
    {2'b10, 1'b0, 1'b1, 8'h00, 8'hB2},  // R4
    {2'b11, 1'b1, 1'b1, 8'h3C, 8'h3C},  // R5
    {2'b01, 1'b0, 1'b0, 8'hFF, 8'h78},  // R3
    {2'b00, 1'b1, 1'b1, 8'h00, 8'h78},  // R2
    {2'b11, 1'b0, 1'b0, 8'h81, 8'h81},  // R5
    {2'b10, 1'b1, 1'b0, 8'h00, 8'h40}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic r, input logic l, input logic [7:0] p);
    {s1, s0} = m; sr = r; sl = l; pin = p;
  endtask

  initial begin
    rst_n = 0; drive(2'b00, 0, 0, 8'h00); d0 = 0; d1 = 0;
    #2;
    check("R1 reset value", pout, 8'h00);
    check("R1 taps in reset", {30'd0, tlast, tfirst}, 0);

    // R6: enable truth table, driven while held in reset (register stays 0)
    for (int k = 0; k < 16; k++) begin
      {d1, d0, s1, s0} = k[3:0];
      #0.5;
      check("R6 output enable", oe, (!d0 && !d1 && !(s1 && s0)));
    end
    d0 = 0; d1 = 0;

    // R9: reset overrides clock edges in load mode
    drive(2'b11, 1, 1, 8'hFF);
    @(posedge clk); @(posedge clk); #1;
    check("R9 edges ignored in reset", pout, 8'h00);

    @(negedge clk); rst_n = 1; drive(2'b00, 0, 0, 8'h00);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][19:18], VEC[v][17], VEC[v][16], VEC[v][15:8]);
      #1;
      check("R6 enable before edge", oe, (VEC[v][19:18] != 2'b11));
      @(posedge clk); #1;
      check("R2-5 vector result", pout, VEC[v][7:0]);
      check("R8 taps", {30'd0, tlast, tfirst}, {30'd0, VEC[v][7], VEC[v][0]});
    end

    // R7: operations continue while the driver is disabled
    @(negedge clk); d0 = 1; drive(2'b11, 0, 0, 8'h5A);
    #1 check("R7 disabled during load", oe, 0);
    @(posedge clk); #1 check("R7 load while disabled", pout, 8'h5A);
    @(negedge clk); drive(2'b01, 1, 0, 8'h00);
    #1 check("R7 disable input wins", oe, 0);
    @(posedge clk); #1 check("R7 shift while disabled", pout, 8'hB5);
    @(negedge clk); d0 = 0; d1 = 1; drive(2'b00, 0, 0, 8'h00);
    #1 check("R6 second disable", oe, 0);
    @(negedge clk); d1 = 0;
    #1 check("R7 enable restored", oe, 1);
    check("R7 state kept", pout, 8'hB5);

    // R3: fill with ones from the serial input
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); drive(2'b01, 1, 0, 8'h00);
    end
    @(posedge clk); #1 check("R3 eight ones shifted in", pout, 8'hFF);
    check("R8 taps full", {30'd0, tlast, tfirst}, 3);

    // R1: reset asserted while clock is high, mid-cycle
    @(posedge clk); #2 rst_n = 0;
    #1 check("R1 async clear mid-cycle", pout, 8'h00);
    drive(2'b11, 0, 0, 8'hC3);
    @(posedge clk); #1 check("R9 load blocked by reset", pout, 8'h00);
    @(negedge clk); rst_n = 1; drive(2'b00, 0, 0, 8'hC3);
    @(posedge clk); #1 check("R2 hold after reset", pout, 8'h00);
    @(negedge clk); drive(2'b10, 0, 1, 8'h00);
    @(posedge clk); #1 check("R4 single one in at top", pout, 8'h80);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule